// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This engine copies data by walking a chain of transfer descriptors held in memory. Software writes the address of the first descriptor to the start register. The engine then fetches the descriptor's three words, copies the stated number of bytes from the source address to the destination address one 32-bit word at a time, and moves on to the descriptor 12 bytes further on. When the descriptor marked as last completes, the engine stops and raises its interrupt.

The engine records what happened in a five-bit status register. A failed data read, a failed data write or a fault in the descriptor array stops the walk and sets its own bit. Memory words are little-endian. When a transfer ends partway through a word, the final write enables only the low-order bytes that the byte count still covers.

Top module: `sg_dma_walker`

## Requirements
- R1: A descriptor is three consecutive 32-bit words: source address at +0, destination address at +4, control word at +8. The next descriptor starts 12 bytes after the current one.
- R2: Bits 17:0 of the control word give the byte count, and bits 30:18 are ignored. Data moves as words from ascending addresses. Every write but the last has `mem_be`=4'hF. The last write has `mem_be`=4'hF when the remaining count is 4 or more, and otherwise enables the remaining 1, 2 or 3 low-order bytes (4'h1, 4'h3, 4'h7).
- R3: Bit 31 of the control word is the last flag. When that descriptor completes, the engine sets status bit 0 (read completed) and status bit 1 (write completed), raises `irq` and stops.
- R4: A register read at offset 0x4 returns the status, zero-extended: bit 0 read completed, bit 1 write completed, bit 2 read error, bit 3 write error, bit 4 descriptor-array error. A read at offset 0x0 returns the start address last accepted.
- R5: An error response to a source read sets status bit 2 and raises `irq`. The engine stops without issuing the write for that word.
- R6: An error response to a destination write sets status bit 3, raises `irq` and stops the engine.
- R7: An error response to a descriptor fetch sets status bit 4, raises `irq` and stops the engine.
- R8: If 8 descriptors complete and none has the last flag, the engine sets status bit 4 and stops after exactly 24 descriptor fetches. It leaves `irq` low.
- R9: A descriptor whose byte count is zero makes no data access and counts as complete.
- R10: A write to offset 0x0 while the engine is idle clears the status and `irq`, stores the start address and begins a walk. Such a write made while a walk is in progress has no effect.
- R11: After reset, `irq` is 0, the status is 0 and `mem_req` is 0.
- R12: Once `mem_req` is raised, it stays high with an unchanged address, write enable, write data and byte enables until `mem_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset (0x0 start, 0x4 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data, little-endian |
| mem_be | output | 4 | Byte enables for a write |
| mem_ack | input | 1 | Response strobe for the pending request |
| mem_err | input | 1 | Error flag that qualifies `mem_ack` |
| mem_rdata | input | 32 | Read data that arrives with `mem_ack` |
| irq | output | 1 | Interrupt, held until the next accepted start |

## Verification
The assertions assume that `mem_ack` is high only while a request is pending, and that `mem_err` means something only together with `mem_ack`. The bench's memory model acknowledges exactly one cycle after it sees a request and drops the acknowledgement on the next cycle, so it never acknowledges twice. The assertions also assume that every address is word-aligned. The bench places all descriptors, sources and destinations on word boundaries. It injects errors only through the model's acknowledgement, on one chosen address.

// File: rtl/sg_dma_walker.sv
module sg_dma_walker #(
  parameter int CNT_W    = 18,
  parameter int MAX_DESC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  output logic        irq
);
  localparam int DI_W = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_READ, S_WRITE, S_NEXT} state_t;

  state_t            state;
  logic [31:0]       start_q, ptr, src, dst, buf_q;
  logic [CNT_W-1:0]  cnt;
  logic              last;
  logic [1:0]        widx;
  logic [DI_W-1:0]   ndesc;
  logic [4:0]        status;
  logic              tail;

  assign tail      = (cnt <= CNT_W'(4));
  assign reg_rdata = (reg_addr == 4'h4) ? {27'd0, status} :
                     (reg_addr == 4'h0) ? start_q : 32'd0;

  assign mem_req   = (state == S_FETCH) || (state == S_READ) || (state == S_WRITE);
  assign mem_we    = (state == S_WRITE);
  assign mem_wdata = buf_q;
  assign mem_addr  = (state == S_FETCH) ? ptr + {28'd0, widx, 2'b00} :
                     (state == S_READ)  ? src :
                     (state == S_WRITE) ? dst : 32'd0;
  assign mem_be    = !mem_we ? 4'h0 :
                     (cnt >= CNT_W'(4)) ? 4'hF : 4'((5'd1 << cnt[1:0]) - 5'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; start_q <= '0; ptr <= '0; src <= '0; dst <= '0;
      buf_q <= '0; cnt <= '0; last <= 1'b0; widx <= '0; ndesc <= '0;
      status <= '0; irq <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (reg_we && reg_addr == 4'h0) begin
          start_q <= reg_wdata; ptr <= reg_wdata;
          status <= '0; irq <= 1'b0; ndesc <= '0; widx <= '0;
          state <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          if (mem_err) begin
            status[4] <= 1'b1; irq <= 1'b1; state <= S_IDLE;
          end else begin
            case (widx)
              2'd0: src <= mem_rdata;
              2'd1: dst <= mem_rdata;
              default: begin
                cnt  <= mem_rdata[CNT_W-1:0];
                last <= mem_rdata[31];
              end
            endcase
            if (widx == 2'd2) begin
              widx  <= '0;
              ptr   <= ptr + 32'd12;
              state <= (mem_rdata[CNT_W-1:0] == '0) ? S_NEXT : S_READ;
            end else begin
              widx <= widx + 2'd1;
            end
          end
        end
        S_READ: if (mem_ack) begin
          if (mem_err) begin
            status[2] <= 1'b1; irq <= 1'b1; state <= S_IDLE;
          end else begin
            buf_q <= mem_rdata;
            if (tail && last) status[0] <= 1'b1;
            state <= S_WRITE;
          end
        end
        S_WRITE: if (mem_ack) begin
          if (mem_err) begin
            status[3] <= 1'b1; irq <= 1'b1; state <= S_IDLE;
          end else begin
            src <= src + 32'd4;
            dst <= dst + 32'd4;
            if (tail) begin
              cnt <= '0; state <= S_NEXT;
            end else begin
              cnt <= cnt - CNT_W'(4); state <= S_READ;
            end
          end
        end
        S_NEXT: begin
          if (last) begin
            status[1:0] <= 2'b11; irq <= 1'b1; state <= S_IDLE;
          end else if (ndesc == DI_W'(MAX_DESC - 1)) begin
            status[4] <= 1'b1; state <= S_IDLE;
          end else begin
            ndesc <= ndesc + 1'b1; state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_wdata) && $stable(mem_be)); // R12
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> status[0]); // R3
  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status[4:2]) && !(status[1] && (status[4:2] != 3'b000))); // R4
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (status[4:1] != 4'b0000)); // R3
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(reg_we && reg_addr == 4'h0) |=> irq); // R10
  AST_WRITE_BE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_be != 4'h0); // R2
  AST_NO_REQ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !mem_req); // R5
endmodule

// File: tb/sg_dma_walker_test.sv
module sg_dma_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = 32'd0;
  logic        irq;

  int checks = 0, errors = 0, cyc = 0, acks = 0;
  logic [31:0] mem [256];
  logic        err_en = 1'b0;
  logic [31:0] err_at = 32'd0;

  always #10 clk = ~clk;

  sg_dma_walker uut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_ack <= mem_req && !mem_ack;
    mem_err <= mem_req && !mem_ack && err_en && (mem_addr == err_at);
    mem_rdata <= mem[mem_addr[9:2]];
    if (mem_req && mem_ack) acks <= acks + 1;
    if (mem_req && mem_ack && mem_we && !mem_err)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_addr = 4'h4;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata; reg_addr = 4'h4;
  endtask

  task automatic wait_end();
    int n = 0;
    @(negedge clk); reg_addr = 4'h4;
    while (reg_rdata[4:1] == 4'b0000 && n < 3000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    if (n >= 3000) chk("watchdog-walk", 1, 0);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 32'hAAAA_AAAA;
    for (int i = 0; i < 16; i++) mem[64 + i] = 32'h0403_0201 + 32'h0404_0404 * i;
  endtask

  task automatic put_desc(input int w, input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    mem[w] = s; mem[w + 1] = d; mem[w + 2] = c;
  endtask

  function automatic logic [31:0] expect_word(input int i, input int n);
    logic [31:0] sw = 32'h0403_0201 + 32'h0404_0404 * i;
    logic [31:0] r = 32'hAAAA_AAAA;
    for (int b = 0; b < 4; b++) if (4 * i + b < n) r[8*b +: 8] = sw[8*b +: 8];
    return r;
  endfunction

  localparam int NV = 7;
  localparam logic [17:0] LENS [NV] = '{18'd4, 18'd1, 18'd2, 18'd3, 18'd7, 18'd16, 18'd13};

  logic [31:0] rv;

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    chk("R11 irq", irq, 0); chk("R11 req", mem_req, 0);
    rd_reg(4'h4, rv); chk("R11 status", rv, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      clear_mem();
      put_desc(0, 32'h100, 32'h200, 32'h8000_0000 | 32'(LENS[v]));
      wr_reg(4'h0, 32'h0);
      wait_end();
      rd_reg(4'h4, rv); chk("R3 status", rv, 32'h3);
      chk("R3 irq", irq, 1);
      for (int i = 0; i < 5; i++)
        chk("R2 data", mem[128 + i], expect_word(i, int'(LENS[v])));
    end

    clear_mem();
    put_desc(4, 32'h100, 32'h200, 32'h7FFC_0008);
    put_desc(7, 32'h110, 32'h210, 32'h0000_0000);
    put_desc(10, 32'h108, 32'h220, 32'h8000_0004);
    wr_reg(4'h0, 32'h10);
    wait_end();
    rd_reg(4'h4, rv); chk("R1 chain status", rv, 32'h3);
    chk("R2 reserved ignored w0", mem[128], expect_word(0, 8));
    chk("R2 reserved ignored w2", mem[130], 32'hAAAA_AAAA);
    chk("R1 third desc", mem[136], expect_word(2, 12));
    chk("R9 zero count untouched", mem[132], 32'hAAAA_AAAA);
    rd_reg(4'h0, rv); chk("R4 start readback", rv, 32'h10);

    clear_mem();
    put_desc(0, 32'h104, 32'h200, 32'h8000_0008);
    err_en = 1'b1; err_at = 32'h104;
    wr_reg(4'h0, 32'h0);
    wait_end();
    rd_reg(4'h4, rv); chk("R5 status", rv, 32'h4);
    chk("R5 irq", irq, 1);
    chk("R5 no write", mem[128], 32'hAAAA_AAAA);

    clear_mem();
    put_desc(0, 32'h100, 32'h200, 32'h8000_000C);
    err_at = 32'h204;
    wr_reg(4'h0, 32'h0);
    wait_end();
    rd_reg(4'h4, rv); chk("R6 status", rv, 32'h8);
    chk("R6 irq", irq, 1);
    chk("R6 first word kept", mem[128], expect_word(0, 12));
    chk("R6 stopped", mem[130], 32'hAAAA_AAAA);

    clear_mem();
    put_desc(0, 32'h100, 32'h200, 32'h0000_0004);
    err_at = 32'h10;
    wr_reg(4'h0, 32'h0);
    wait_end();
    rd_reg(4'h4, rv); chk("R7 status", rv, 32'h10);
    chk("R7 irq", irq, 1);
    err_en = 1'b0;

    clear_mem();
    for (int d = 0; d < 9; d++) put_desc(3 * d, 32'h100, 32'h200, 32'h0);
    put_desc(24, 32'h100, 32'h200, 32'h8000_0004);
    acks = 0;
    wr_reg(4'h0, 32'h0);
    wait_end();
    rd_reg(4'h4, rv); chk("R8 status", rv, 32'h10);
    chk("R8 irq low", irq, 0);
    chk("R8 fetch count", acks, 24);
    chk("R9 no data access", mem[128], 32'hAAAA_AAAA);

    clear_mem();
    put_desc(0, 32'h100, 32'h200, 32'h8000_0020);
    put_desc(12, 32'h100, 32'h280, 32'h8000_0004);
    wr_reg(4'h0, 32'h0);
    repeat (4) @(negedge clk);
    wr_reg(4'h0, 32'h30);
    wait_end();
    rd_reg(4'h4, rv); chk("R10 busy write ignored status", rv, 32'h3);
    rd_reg(4'h0, rv); chk("R10 start kept", rv, 32'h0);
    chk("R10 other dest untouched", mem[160], 32'hAAAA_AAAA);
    chk("R10 walk data", mem[135], expect_word(7, 32));

    wr_reg(4'h0, 32'h30);
    chk("R10 irq cleared", irq, 0);
    rd_reg(4'h4, rv); chk("R10 status cleared", rv, 32'h0);
    wait_end();
    chk("R10 new walk data", mem[160], expect_word(0, 4));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule